// File: doc/BRIEF.md
# Doze CPU Clock Ratio Divider

This block produces a clock-enable strobe for the processor core that fires at a programmable fraction of the system clock rate. The system clock stays running and the peripherals keep their full rate; only the core advances on strobe cycles. A power-of-two ratio code selects how many system cycles make up one core cycle. A doze enable bit turns the reduced rate on. A recover bit lets any interrupt event drop the core back to full speed by clearing that enable in hardware.

The three settings sit in small registers. Each register has its own write strobe, so software can change one field without touching the others. The current doze enable is driven back out for register readback. A new ratio or enable takes effect only at the next strobe boundary, so the core never sees a shortened cycle.

Top module: `doze_cpu_divider`

## Requirements
- R1: After reset the doze enable reads 0, the recover bit is 0 and the ratio code holds 3 (binary 011). The strobe is high on every cycle until the enable is set.
- R2: With the doze enable at 1, ratio code c gives one strobe every 2^c system cycles (code 0 means every cycle, code 7 means every 128 cycles).
- R3: With the doze enable at 0, the strobe is high on every cycle, whatever the ratio code holds.
- R4: Each strobe is exactly one system cycle wide. When the period N is greater than 1, N-1 low cycles separate two consecutive strobes.
- R5: When the recover bit is 1 and the interrupt pulse is high on a clock edge, the doze enable reads 0 from the following cycle. The strobe returns to every cycle after the period in progress completes.
- R6: When the recover bit is 0, the interrupt pulse leaves the doze enable and the strobe spacing unchanged.
- R7: A change of ratio code or doze enable is sampled only when a strobe occurs, so the period in progress keeps its full length.
- R8: A write of 1 to the doze enable in the same cycle as an interrupt-driven clear leaves the enable at 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ratio_we | input | 1 | Write strobe for the ratio code register |
| ratio_wdata | input | CODE_W | New ratio code; period is 2^code |
| doze_we | input | 1 | Write strobe for the doze enable bit |
| doze_wdata | input | 1 | New doze enable value |
| recover_we | input | 1 | Write strobe for the recover bit |
| recover_wdata | input | 1 | New recover value |
| irq_pulse | input | 1 | One-cycle interrupt event |
| cpu_ce | output | 1 | Core clock-enable strobe |
| doze_en_q | output | 1 | Current doze enable, for readback |

## Verification
A stuck or mis-decoded reload value in the divider shows up as a wrong strobe spacing. It is visible within one full period of the selected ratio after the next boundary, which is at most 128 cycles. A doze enable that the interrupt path fails to clear, or clears wrongly, appears on the readback port one cycle after the interrupt edge. The strobe then keeps the wrong rate from the next boundary on. A period that restarts at a configuration write shows as a short gap between two strobes that straddle that write.

// File: rtl/doze_pkg.sv
package doze_pkg;

   // Largest ratio-code width the divider supports (2^(2^4-1) cycles max).
   localparam int unsigned DOZE_CODE_W_MAX = 4;

   // Flag bits of the control registers.
   typedef struct packed {
      logic active;
      logic recover;
   } doze_flags_t;

endpackage

// File: rtl/doze_ctl_regs.sv
module doze_ctl_regs #(
   parameter int unsigned CODE_W     = 3,
   parameter int unsigned RESET_CODE = 3
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              ratio_we,
   input  logic [CODE_W-1:0] ratio_wdata,
   input  logic              doze_we,
   input  logic              doze_wdata,
   input  logic              recover_we,
   input  logic              recover_wdata,
   input  logic              irq_pulse,
   output logic [CODE_W-1:0] code_o,
   output doze_pkg::doze_flags_t flags_o
);

   localparam logic [CODE_W-1:0] CODE_RST = CODE_W'(RESET_CODE);

   logic [CODE_W-1:0]     code_q;
   doze_pkg::doze_flags_t flags_q;
   logic                  hw_clear;

   // An interrupt with recovery armed overrides any software write.
   assign hw_clear = flags_q.recover & irq_pulse;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         code_q          <= CODE_RST;
         flags_q.active  <= 1'b0;
         flags_q.recover <= 1'b0;
      end else begin
         if (ratio_we)
            code_q <= ratio_wdata;
         if (recover_we)
            flags_q.recover <= recover_wdata;
         if (hw_clear)
            flags_q.active <= 1'b0;
         else if (doze_we)
            flags_q.active <= doze_wdata;
      end
   end

   assign code_o  = code_q;
   assign flags_o = flags_q;

   AST_IRQ_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
      (flags_q.recover && irq_pulse) |=> !flags_q.active); // R5

   AST_IRQ_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
      (!flags_q.recover && irq_pulse && !doze_we) |=> $stable(flags_q.active)); // R6

   AST_CLEAR_WINS: assert property (@(posedge clk) disable iff (!rst_n)
      (flags_q.recover && irq_pulse && doze_we && doze_wdata) |=> !flags_q.active); // R8

endmodule

// File: rtl/doze_strobe_gen.sv
module doze_strobe_gen #(
   parameter int unsigned CODE_W = 3
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              active_i,
   input  logic [CODE_W-1:0] code_i,
   output logic              cpu_ce
);

   localparam int unsigned NCODES = 1 << CODE_W;
   localparam int unsigned CNT_W  = NCODES - 1;

   logic [CNT_W-1:0] reload_next;
   logic [CNT_W-1:0] reload_q;
   logic [CNT_W-1:0] cnt_q;

   // Reload value 2^code - 1 as a thermometer: bit b set when code > b.
   for (genvar b = 0; b < CNT_W; b++) begin : g_thermo
      assign reload_next[b] = active_i && (code_i > CODE_W'(b));
   end

   assign cpu_ce = (cnt_q == '0);

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         cnt_q    <= '0;
         reload_q <= '0;
      end else if (cpu_ce) begin
         cnt_q    <= reload_next;
         reload_q <= reload_next;
      end else begin
         cnt_q    <= cnt_q - 1'b1;
      end
   end

   AST_CNT_IN_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
      cnt_q <= reload_q); // R4

   AST_PERIOD_HELD: assert property (@(posedge clk) disable iff (!rst_n)
      !cpu_ce |=> $stable(reload_q)); // R7

   AST_FULL_RATE_OFF: assert property (@(posedge clk) disable iff (!rst_n)
      (cpu_ce && !active_i) |=> cpu_ce); // R3

   AST_STROBE_ONE_WIDE: assert property (@(posedge clk) disable iff (!rst_n)
      (cpu_ce && active_i && (code_i != '0)) |=> !cpu_ce); // R4

endmodule

// File: rtl/doze_cpu_divider.sv
module doze_cpu_divider #(
   parameter int unsigned CODE_W     = 3,
   parameter int unsigned RESET_CODE = 3
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              ratio_we,
   input  logic [CODE_W-1:0] ratio_wdata,
   input  logic              doze_we,
   input  logic              doze_wdata,
   input  logic              recover_we,
   input  logic              recover_wdata,
   input  logic              irq_pulse,
   output logic              cpu_ce,
   output logic              doze_en_q
);

   if (CODE_W < 1 || CODE_W > doze_pkg::DOZE_CODE_W_MAX) begin : g_bad_width
      $error("doze_cpu_divider: CODE_W out of range");
   end
   if (RESET_CODE >= (1 << CODE_W)) begin : g_bad_reset
      $error("doze_cpu_divider: RESET_CODE does not fit CODE_W");
   end

   logic [CODE_W-1:0]     code;
   doze_pkg::doze_flags_t flags;

   doze_ctl_regs #(
      .CODE_W     (CODE_W),
      .RESET_CODE (RESET_CODE)
   ) u_regs (
      .clk           (clk),
      .rst_n         (rst_n),
      .ratio_we      (ratio_we),
      .ratio_wdata   (ratio_wdata),
      .doze_we       (doze_we),
      .doze_wdata    (doze_wdata),
      .recover_we    (recover_we),
      .recover_wdata (recover_wdata),
      .irq_pulse     (irq_pulse),
      .code_o        (code),
      .flags_o       (flags)
   );

   doze_strobe_gen #(
      .CODE_W (CODE_W)
   ) u_strobe (
      .clk      (clk),
      .rst_n    (rst_n),
      .active_i (flags.active),
      .code_i   (code),
      .cpu_ce   (cpu_ce)
   );

   assign doze_en_q = flags.active;

   AST_RESET_STATE: assert property (@(posedge clk)
      !rst_n |=> (!doze_en_q && cpu_ce)); // R1

endmodule

// File: tb/sim_doze_cpu_divider.sv
module sim_doze_cpu_divider;

   localparam time CLK_P = 20ns;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       ratio_we = 1'b0;
   logic [2:0] ratio_wdata = '0;
   logic       doze_we = 1'b0;
   logic       doze_wdata = 1'b0;
   logic       recover_we = 1'b0;
   logic       recover_wdata = 1'b0;
   logic       irq_pulse = 1'b0;
   logic       cpu_ce;
   logic       doze_en_q;

   int checks = 0;
   int errors = 0;

   always #(CLK_P/2) clk = ~clk;

   doze_cpu_divider u0 (
      .clk(clk), .rst_n(rst_n),
      .ratio_we(ratio_we), .ratio_wdata(ratio_wdata),
      .doze_we(doze_we), .doze_wdata(doze_wdata),
      .recover_we(recover_we), .recover_wdata(recover_wdata),
      .irq_pulse(irq_pulse), .cpu_ce(cpu_ce), .doze_en_q(doze_en_q)
   );

   task automatic check(input int actual, input int expected, input string req);
      checks++;
      if (actual != expected) begin
         errors++;
         $display("FAIL %s: actual=%0d expected=%0d", req, actual, expected);
      end
   endtask

   task automatic wr_ratio(input logic [2:0] c);
      ratio_we = 1'b1; ratio_wdata = c;
      @(posedge clk); @(negedge clk);
      ratio_we = 1'b0;
   endtask

   task automatic wr_doze(input logic v);
      doze_we = 1'b1; doze_wdata = v;
      @(posedge clk); @(negedge clk);
      doze_we = 1'b0;
   endtask

   task automatic wr_recover(input logic v);
      recover_we = 1'b1; recover_wdata = v;
      @(posedge clk); @(negedge clk);
      recover_we = 1'b0;
   endtask

   task automatic pulse_irq();
      irq_pulse = 1'b1;
      @(posedge clk); @(negedge clk);
      irq_pulse = 1'b0;
   endtask

   // Stay on a negedge where the strobe is high.
   task automatic sync_strobe();
      while (!cpu_ce) @(negedge clk);
   endtask

   // From a strobe cycle, count cycles to the next strobe.
   task automatic gap(output int n);
      n = 0;
      do begin
         @(negedge clk);
         n++;
      end while (!cpu_ce && n < 1000);
   endtask

   task automatic t_reset();
      int g;
      check(int'(doze_en_q), 0, "R1 enable after reset");
      check(int'(cpu_ce), 1, "R1 strobe after reset");
      for (int i = 0; i < 4; i++) begin
         gap(g);
         check(g, 1, "R1 full rate after reset");
      end
   endtask

   task automatic t_default_ratio();
      int g;
      wr_doze(1'b1);
      check(int'(doze_en_q), 1, "R1 enable readback");
      sync_strobe();
      gap(g);
      check(g, 8, "R1 reset code gives divide by 8");
   endtask

   task automatic t_all_codes();
      int g;
      for (int c = 0; c < 8; c++) begin
         wr_ratio(3'(c));
         sync_strobe();
         gap(g);
         check(g, 1 << c, $sformatf("R2 code %0d", c));
         if (c > 0) begin
            for (int k = 1; k < (1 << c); k++) begin
               @(negedge clk);
               if (cpu_ce) begin
                  check(k, 1 << c, "R4 strobe wider than one cycle");
                  break;
               end
            end
            check(int'(cpu_ce), 0, "R4 low between strobes");
         end
      end
   endtask

   task automatic t_no_shorten();
      int g;
      wr_ratio(3'd7);
      sync_strobe();
      gap(g);                      // first full 128 period
      check(g, 128, "R2 code 7");
      // now at a strobe; period 128 in progress
      for (int i = 0; i < 5; i++) @(negedge clk);
      wr_ratio(3'd0);              // 6 cycles elapsed
      g = 6;
      while (!cpu_ce) begin @(negedge clk); g++; end
      check(g, 128, "R7 period not shortened by ratio write");
      gap(g);
      check(g, 1, "R7 new ratio after boundary");
   endtask

   task automatic t_disable_forces_full();
      int g;
      wr_ratio(3'd5);
      sync_strobe();
      gap(g);
      check(g, 32, "R2 code 5");
      wr_doze(1'b0);
      sync_strobe();
      gap(g);
      check(g, 1, "R3 enable off forces 1:1");
      gap(g);
      check(g, 1, "R3 stays 1:1 with code 5");
   endtask

   task automatic t_irq_no_recover();
      int g;
      wr_recover(1'b0);
      wr_ratio(3'd2);
      wr_doze(1'b1);
      sync_strobe();
      pulse_irq();
      check(int'(doze_en_q), 1, "R6 irq ignored with recover off");
      sync_strobe();
      gap(g);
      check(g, 4, "R6 spacing unchanged");
   endtask

   task automatic t_irq_recover();
      int g;
      wr_recover(1'b1);
      wr_ratio(3'd4);
      sync_strobe();
      gap(g);
      check(g, 16, "R2 code 4");
      pulse_irq();
      check(int'(doze_en_q), 0, "R5 irq clears enable");
      sync_strobe();
      gap(g);
      check(g, 1, "R5 back to full rate");
   endtask

   task automatic t_clear_wins();
      wr_doze(1'b1);
      check(int'(doze_en_q), 1, "R8 setup enable");
      doze_we = 1'b1; doze_wdata = 1'b1; irq_pulse = 1'b1;
      @(posedge clk); @(negedge clk);
      doze_we = 1'b0; irq_pulse = 1'b0;
      check(int'(doze_en_q), 0, "R8 clear beats write");
   endtask

   initial begin
      #(CLK_P * 150000);
      errors++; checks++;
      $display("FAIL watchdog: actual=timeout expected=done");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      t_reset();
      t_default_ratio();
      t_all_codes();
      t_no_shorten();
      t_disable_forces_full();
      t_irq_no_recover();
      t_irq_recover();
      t_clear_wins();
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end

endmodule